// File: doc/BRIEF.md
# Multi-Port PHY Interrupt Aggregator

This block gathers interrupt events from six PHY ports and drives one shared active-low interrupt line. Each port keeps a sticky event status register, an event enable mask and a small control register. The control register holds a port-level interrupt enable and a force bit. A one-cycle event pulse sets its status bit, and the bit stays set until software reads the status register. That read returns the contents and clears them in the same access. An event that arrives in the same cycle as the read is kept, so no event is lost.

Within a port, each status bit is ANDed with its mask bit and the results are ORed. The force bit is then ORed in, and the port enable gates the result. The port results are ORed across all ports. That OR is registered, so the interrupt pin falls one clock after the status bit that causes it is set.

Software reaches the registers through a plain read/write strobe interface. The upper address bits select the port and the low two bits select the register. Read data is combinational and shows the register contents before any clear-on-read takes effect.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every status, mask and control register reads zero and irq_n is high.
- R2: A pulse on an event input sets the matching status bit at the next clock edge. The bit stays set, with or without further pulses, until the port's status register is read.
- R3: A read of the status register (low address bits 0) returns its contents on reg_rdata in the same cycle and clears all of that port's status bits at the clock edge ending the read.
- R4: An event pulse in the same cycle as a status read of that port sets its bit after the clear, so the bit reads 1 on the next status read.
- R5: A status bit whose mask bit (register at low address bits 1, bit n masks event n) is zero sets status but does not pull irq_n low.
- R6: irq_n falls at the second clock edge after the event pulse, one edge after the enabled status bit is set. It rises one edge after the last cause is removed.
- R7: Control bit 0 (register at low address bits 2) is the port enable. While it is zero, nothing in that port can pull irq_n low.
- R8: Control bit 1 is the force bit. With the port enabled, it pulls irq_n low one edge after it is written, regardless of status and mask. With the port disabled, it has no effect.
- R9: irq_n stays low while any port still has an interrupt cause, and rises only after every port's cause is removed.
- R10: Address = {port index, low two bits}. Writes to the status register have no effect. Low bits 3 read zero. The control register reads back only bits 1:0. Port indices at or above the port count read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_PORTS*NUM_EVENTS | Event pulses; port p uses bits [p*NUM_EVENTS +: NUM_EVENTS] |
| reg_addr | input | PORT_W+2 | Register address: port index above, register select in bits 1:0 |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rd_en | input | 1 | Read strobe; a status read clears that port's status |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| irq_n | output | 1 | Shared interrupt, active low, registered |

## Verification
On every cycle the assertions check three things. Status bits stay set unless a read clears them. A read with no coinciding event leaves the status empty, and a coinciding event survives the read. The registered pin follows the OR of the port interrupts exactly one edge later. Only the bench's scenarios can show the address decode:
- the status register ignores writes,
- accesses to invalid ports have no effect,
- the control register reads back only its two defined bits.

The bench scenarios also cover how mask, port enable and force combine across several ports. They measure the exact edge at which the pin falls and rises, as seen at the ports.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic force_irq;
        logic port_en;
    } ctrl_t;

endpackage

// File: rtl/irq_port_regs.sv
module irq_port_regs
    import irq_agg_pkg::*;
#(
    parameter int NUM_EVENTS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] evt_pulse,
    input  logic                  mask_we,
    input  logic                  ctrl_we,
    input  logic                  stat_rd,
    input  logic [NUM_EVENTS-1:0] wr_mask,
    input  ctrl_t                 wr_ctrl,
    output logic [NUM_EVENTS-1:0] stat_o,
    output logic [NUM_EVENTS-1:0] mask_o,
    output ctrl_t                 ctrl_o,
    output logic                  port_irq
);

    typedef struct packed {
        logic [NUM_EVENTS-1:0] stat;
        logic [NUM_EVENTS-1:0] mask;
        ctrl_t                 ctrl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear-on-read first, then new events: a coinciding event survives
        st_d.stat = (stat_rd ? '0 : st_q.stat) | evt_pulse;
        if (mask_we) st_d.mask = wr_mask;
        if (ctrl_we) st_d.ctrl = wr_ctrl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o   = st_q.stat;
    assign mask_o   = st_q.mask;
    assign ctrl_o   = st_q.ctrl;
    assign port_irq = st_q.ctrl.port_en &
                      ((|(st_q.stat & st_q.mask)) | st_q.ctrl.force_irq);

    // R2: without a read, no set status bit is lost
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((st_q.stat & $past(st_q.stat)) == $past(st_q.stat)));

    // R3: a read with no coinciding event empties the status
    a_r3_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && evt_pulse == '0) |=> (st_q.stat == '0));

    // R4: events coinciding with a read are the only bits left afterwards
    a_r4_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (st_q.stat == $past(evt_pulse)));

endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
    parameter int NUM_PORTS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] port_irq,
    output logic                 irq_n
);

    typedef struct packed {
        logic irq_n;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.irq_n = ~(|port_irq);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{irq_n: 1'b1};
        else        st_q <= st_d;
    end

    assign irq_n = st_q.irq_n;

    // R6 / R9: any port cause pulls the pin low one edge later
    a_r6_assert_next: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_irq) |=> !irq_n);

    // R9: with no port cause the pin is released one edge later
    a_r9_release_next: assert property (@(posedge clk) disable iff (!rst_n)
        !(|port_irq) |=> irq_n);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter  int NUM_PORTS  = 6,
    parameter  int NUM_EVENTS = 8,
    parameter  int DATA_W     = 16,
    localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W     = PORT_W + 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PORTS*NUM_EVENTS-1:0] evt_i,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic                            reg_wr_en,
    input  logic [DATA_W-1:0]               reg_wdata,
    input  logic                            reg_rd_en,
    output logic [DATA_W-1:0]               reg_rdata,
    output logic                            irq_n
);

    logic [PORT_W-1:0]     port_idx;
    reg_sel_e              sel;
    logic                  port_ok;
    logic [NUM_PORTS-1:0]  port_irq;
    logic [NUM_EVENTS-1:0] stat_all [NUM_PORTS];
    logic [NUM_EVENTS-1:0] mask_all [NUM_PORTS];
    ctrl_t                 ctrl_all [NUM_PORTS];
    logic                  unused_wdata;

    assign port_idx     = reg_addr[ADDR_W-1:2];
    assign sel          = reg_sel_e'(reg_addr[1:0]);
    assign port_ok      = int'(port_idx) < NUM_PORTS;
    assign unused_wdata = ^reg_wdata;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic hit;
        assign hit = port_ok && (port_idx == PORT_W'(g));

        irq_port_regs #(.NUM_EVENTS(NUM_EVENTS)) i_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_pulse (evt_i[g*NUM_EVENTS +: NUM_EVENTS]),
            .mask_we   (hit && reg_wr_en && sel == SEL_MASK),
            .ctrl_we   (hit && reg_wr_en && sel == SEL_CTRL),
            .stat_rd   (hit && reg_rd_en && sel == SEL_STAT),
            .wr_mask   (reg_wdata[NUM_EVENTS-1:0]),
            .wr_ctrl   (ctrl_t'(reg_wdata[1:0])),
            .stat_o    (stat_all[g]),
            .mask_o    (mask_all[g]),
            .ctrl_o    (ctrl_all[g]),
            .port_irq  (port_irq[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (port_ok) begin
            case (sel)
                SEL_STAT: reg_rdata[NUM_EVENTS-1:0] = stat_all[port_idx];
                SEL_MASK: reg_rdata[NUM_EVENTS-1:0] = mask_all[port_idx];
                SEL_CTRL: reg_rdata[1:0]            = ctrl_all[port_idx];
                default:  reg_rdata                 = '0;
            endcase
        end
    end

    irq_combine #(.NUM_PORTS(NUM_PORTS)) i_combine (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_irq (port_irq),
        .irq_n    (irq_n)
    );

    // R10: an invalid port index always reads zero
    a_r10_bad_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !port_ok |-> (reg_rdata == '0));

endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;

    localparam int NP = 6;
    localparam int NE = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP*NE-1:0] evt = '0;
    logic [4:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rdata;
    logic          irq_n;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    always #5 clk = ~clk;

    irq_aggregator #(.NUM_PORTS(NP), .NUM_EVENTS(NE), .DATA_W(DW)) i_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr(addr),
        .reg_wr_en(wr_en), .reg_wdata(wdata), .reg_rd_en(rd_en),
        .reg_rdata(rdata), .irq_n(irq_n)
    );

    // monitor: compare read data mid-cycle against the scoreboard
    always @(negedge clk) begin
        if (rd_en) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard: read with no expected item, got %h", rdata);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rdata !== e) begin
                    fails++;
                    $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(int p, int s, logic [DW-1:0] d);
        step();
        addr = {p[2:0], s[1:0]}; wdata = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(int p, int s, logic [DW-1:0] e, string t);
        step();
        addr = {p[2:0], s[1:0]}; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        step();
        rd_en = 1'b0;
    endtask

    task automatic pulse(int p, logic [NE-1:0] b);
        step();
        evt = '0; evt[p*NE +: NE] = b;
        step();
        evt = '0;
    endtask

    task automatic chk_irq(logic e, string t);
        checks++;
        if (irq_n !== e) begin
            fails++;
            $display("FAIL %s: irq_n actual %b expected %b", t, irq_n, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk_irq(1'b1, "R1 reset irq_n");
        rd(0, 0, 16'h0, "R1 status reset");
        rd(3, 1, 16'h0, "R1 mask reset");
        rd(5, 2, 16'h0, "R1 ctrl reset");

        // R2 / R5: masked-off events are sticky but silent
        pulse(0, 8'h05);
        step(); step();
        chk_irq(1'b1, "R5 masked event no irq");
        rd(0, 0, 16'h0005, "R2 sticky status");
        rd(0, 0, 16'h0000, "R3 cleared after read");

        // R6: timing of assert and release
        wr(0, 1, 16'h0004);
        wr(0, 2, 16'h0001);
        pulse(0, 8'h04);
        chk_irq(1'b1, "R6 not yet low when status set");
        step();
        chk_irq(1'b0, "R6 low one edge after status");
        rd(0, 0, 16'h0004, "R3 read returns pre-clear value");
        chk_irq(1'b0, "R6 still low at clear edge");
        step();
        chk_irq(1'b1, "R6 released one edge after clear");

        // R4: event coinciding with a read survives
        step();
        addr = {3'd0, 2'd0}; rd_en = 1'b1; evt[0 +: NE] = 8'h02;
        exp_q.push_back(16'h0000); tag_q.push_back("R4 read with coinciding event");
        step();
        rd_en = 1'b0; evt = '0;
        rd(0, 0, 16'h0002, "R4 coinciding event kept");

        // R7: port enable gates contribution
        wr(2, 1, 16'h00FF);
        pulse(2, 8'h80);
        step(); step();
        chk_irq(1'b1, "R7 disabled port silent");
        wr(2, 2, 16'h0001);
        chk_irq(1'b1, "R7 not yet low at enable edge");
        step();
        chk_irq(1'b0, "R7 enabled port drives irq");
        rd(2, 0, 16'h0080, "R7 status kept while disabled");
        step();
        chk_irq(1'b1, "R7 release after clear");

        // R8: force path
        wr(4, 2, 16'h0003);
        chk_irq(1'b1, "R8 not yet low at force edge");
        step();
        chk_irq(1'b0, "R8 force drives irq");
        wr(4, 2, 16'h0002);
        step();
        chk_irq(1'b1, "R8 force without enable ignored");
        wr(4, 2, 16'h0000);

        // R9: two ports combined
        wr(1, 1, 16'h0001); wr(1, 2, 16'h0001);
        wr(5, 1, 16'h0010); wr(5, 2, 16'h0001);
        step();
        evt = '0; evt[1*NE +: NE] = 8'h01; evt[5*NE +: NE] = 8'h10;
        step();
        evt = '0;
        step();
        chk_irq(1'b0, "R9 two ports low");
        rd(1, 0, 16'h0001, "R9 port1 status");
        step(); step();
        chk_irq(1'b0, "R9 still low while port5 pending");
        rd(5, 0, 16'h0010, "R9 port5 status");
        step();
        chk_irq(1'b1, "R9 released after last port");

        // R10: address decode
        wr(3, 0, 16'h00FF);
        rd(3, 0, 16'h0000, "R10 status write ignored");
        rd(3, 3, 16'h0000, "R10 select 3 reads zero");
        wr(6, 1, 16'h00FF);
        rd(6, 1, 16'h0000, "R10 invalid port reads zero");
        rd(0, 1, 16'h0004, "R10 port0 mask unchanged");
        rd(5, 1, 16'h0010, "R10 port5 mask unchanged");
        wr(3, 2, 16'hFFFF);
        rd(3, 2, 16'h0003, "R10 ctrl upper bits dropped");
        wr(3, 2, 16'h0000);
        step(); step();
        chk_irq(1'b1, "R10 idle after restore");

        step();
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d reads not observed, expected 0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule